// File: doc/BRIEF.md
# Per-Thread Next-PC Unit with Condition-Flag Branching

This block computes the address of the next instruction for one thread of a SIMD compute core. It holds a three-bit condition register of negative, zero and positive flags. A compare instruction loads this register. A later conditional branch tests it against the condition mask carried in the branch instruction. Program addresses are 8 bits wide, so the program space has 256 rows of 16-bit instruction words.

Each thread of the core has one instance of this block. The core's control sequencer supplies the current phase, the shared current PC and the decoded controls. The block's state changes only in the update phase, and only when its thread is enabled. All threads are assumed to converge, so the core takes the next PC of thread 0 as the shared PC for the following fetch.

There is no data stream into or out of the block. Every pin is a plain control or status signal, sampled on the rising clock edge, with no valid/ready handshake and no back-pressure.

Top module: `thread_pc_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `next_pc` reads 0 and `nzp_flags` reads 3'b000.
- R2: In an update edge with `sel_branch` low, `next_pc` becomes `cur_pc + 1`. An update edge is a rising edge where `thread_en` is 1 and `phase` equals 3'd6.
- R3: The increment is modulo 256, so a current PC of 255 gives a next PC of 0.
- R4: In an update edge with `nzp_wr_en` high, `nzp_flags` loads `cmp_code`. The bit order is bit 2 negative, bit 1 zero, bit 0 positive.
- R5: In an update edge with `nzp_wr_en` low, `nzp_flags` keeps its value.
- R6: In an update edge with `sel_branch` high and `(nzp_flags & cond_mask) != 0`, `next_pc` becomes `target`.
- R7: In an update edge with `sel_branch` high and `(nzp_flags & cond_mask) == 0`, `next_pc` becomes `cur_pc + 1`. This includes a mask of 3'b000.
- R8: At an edge where `phase` is not 3'd6, neither `next_pc` nor `nzp_flags` changes.
- R9: At an edge where `thread_en` is 0, neither `next_pc` nor `nzp_flags` changes, whatever the phase.
- R10: When a compare write and a branch occur in the same update edge, the branch tests the flags held before that edge. The new flags are visible only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| thread_en | input | 1 | This thread takes part in the current block |
| phase | input | 3 | Core sequencer phase; 3'd6 is the update phase |
| cur_pc | input | 8 | PC shared by the core for the current instruction |
| sel_branch | input | 1 | Selects the branch path instead of the increment path |
| nzp_wr_en | input | 1 | Loads the condition register from `cmp_code` |
| cond_mask | input | 3 | Condition mask of the branch instruction {n,z,p} |
| target | input | 8 | Immediate branch target |
| cmp_code | input | 3 | Low three bits of the compare result {n,z,p} |
| next_pc | output | 8 | Registered next instruction address |
| nzp_flags | output | 3 | Registered condition flags {n,z,p} |

## Verification
The compare write and the branch decision can both fall on one update edge. The branch must then read the old flags and not the value being written. The bench provokes this by first loading one flag. In the next update it writes a different flag while branching with a mask that matches only the old flag. It repeats this with a mask that matches only the new flag. The jump must be taken in the first case and not in the second, and the written flags must appear only after the edge. Every flag and mask pairing is swept the same way, and the expected result is computed arithmetically in the bench.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int PC_W    = 8;
  localparam int FLAG_W  = 3;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE    = 3'd0,
    PH_FETCH   = 3'd1,
    PH_DECODE  = 3'd2,
    PH_REQUEST = 3'd3,
    PH_WAIT    = 3'd4,
    PH_EXECUTE = 3'd5,
    PH_UPDATE  = 3'd6,
    PH_DONE    = 3'd7
  } phase_e;

  localparam int FLAG_N = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_P = 0;
endpackage

// File: rtl/tpc_flag_reg.sv
module tpc_flag_reg #(
  parameter int FLAG_W = tpc_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] code,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if (upd && wr_en)
      flags_q <= code;
  end

  // R4
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd) && $past(wr_en)) |-> flags_q == $past(code));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(upd) && $past(wr_en))) |-> $stable(flags_q));
endmodule

// File: rtl/tpc_next_sel.sv
module tpc_next_sel #(
  parameter int PC_W   = tpc_pkg::PC_W,
  parameter int FLAG_W = tpc_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              sel_branch,
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [FLAG_W-1:0] mask,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   next_pc_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  logic            hit;
  logic            take;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] pick_pc;

  assign hit     = |(flags_q & mask);
  assign take    = sel_branch & hit;
  assign seq_pc  = cur_pc + STEP;
  assign pick_pc = take ? target : seq_pc;

  always_ff @(posedge clk) begin
    if (rst)
      next_pc_q <= '0;
    else if (upd)
      next_pc_q <= pick_pc;
  end

  // R2 R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd) && !$past(sel_branch))
      |-> next_pc_q == PC_W'($past(cur_pc) + 1));

  // R6 R10
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd) && $past(sel_branch) && ($past(flags_q & mask) != '0))
      |-> next_pc_q == $past(target));

  // R7
  branch_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd) && $past(sel_branch) && ($past(flags_q & mask) == '0))
      |-> next_pc_q == PC_W'($past(cur_pc) + 1));

  // R8 R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd)) |-> $stable(next_pc_q));
endmodule

// File: rtl/thread_pc_unit.sv
module thread_pc_unit #(
  parameter int PC_W    = tpc_pkg::PC_W,
  parameter int FLAG_W  = tpc_pkg::FLAG_W,
  parameter int PHASE_W = tpc_pkg::PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               thread_en,
  input  logic [PHASE_W-1:0] phase,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               sel_branch,
  input  logic               nzp_wr_en,
  input  logic [FLAG_W-1:0]  cond_mask,
  input  logic [PC_W-1:0]    target,
  input  logic [FLAG_W-1:0]  cmp_code,
  output logic [PC_W-1:0]    next_pc,
  output logic [FLAG_W-1:0]  nzp_flags
);
  localparam logic [PHASE_W-1:0] UPD_CODE = PHASE_W'(tpc_pkg::PH_UPDATE);

  logic upd;
  logic [FLAG_W-1:0] flags_q;

  assign upd = thread_en && (phase == UPD_CODE);

  tpc_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .wr_en   (nzp_wr_en),
    .code    (cmp_code),
    .flags_q (flags_q)
  );

  tpc_next_sel #(.PC_W(PC_W), .FLAG_W(FLAG_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .upd        (upd),
    .sel_branch (sel_branch),
    .flags_q    (flags_q),
    .mask       (cond_mask),
    .cur_pc     (cur_pc),
    .target     (target),
    .next_pc_q  (next_pc)
  );

  assign nzp_flags = flags_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (next_pc == '0 && nzp_flags == '0));
endmodule

// File: tb/thread_pc_unit_tb.sv
`timescale 1ns/1ps
module thread_pc_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       thread_en;
  logic [2:0] phase;
  logic [7:0] cur_pc;
  logic       sel_branch;
  logic       nzp_wr_en;
  logic [2:0] cond_mask;
  logic [7:0] target;
  logic [2:0] cmp_code;
  logic [7:0] next_pc;
  logic [2:0] nzp_flags;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_pc;
  logic [2:0] m_nzp;
  bit finished = 0;

  always #10 clk = ~clk;

  thread_pc_unit u_dut (
    .clk(clk), .rst(rst), .thread_en(thread_en), .phase(phase),
    .cur_pc(cur_pc), .sel_branch(sel_branch), .nzp_wr_en(nzp_wr_en),
    .cond_mask(cond_mask), .target(target), .cmp_code(cmp_code),
    .next_pc(next_pc), .nzp_flags(nzp_flags)
  );

  task automatic check_pc(input string tag, input logic [7:0] exp);
    checks++;
    if (next_pc !== exp) begin
      errors++;
      $display("FAIL %s next_pc actual=%0d expected=%0d", tag, next_pc, exp);
    end
  endtask

  task automatic check_nzp(input string tag, input logic [2:0] exp);
    checks++;
    if (nzp_flags !== exp) begin
      errors++;
      $display("FAIL %s nzp_flags actual=%b expected=%b", tag, nzp_flags, exp);
    end
  endtask

  // Drives one cycle at the falling edge, predicts, samples at the next falling edge.
  task automatic step(input logic en, input logic [2:0] ph, input logic [7:0] cp,
                      input logic sel, input logic wr, input logic [2:0] mask,
                      input logic [7:0] tgt, input logic [2:0] code, input string tag);
    thread_en = en; phase = ph; cur_pc = cp; sel_branch = sel;
    nzp_wr_en = wr; cond_mask = mask; target = tgt; cmp_code = code;
    if (en && ph == 3'd6) begin
      m_pc = (sel && ((m_nzp & mask) != 3'b000)) ? tgt : 8'(cp + 8'd1);
      if (wr) m_nzp = code;
    end
    @(posedge clk);
    @(negedge clk);
    check_pc(tag, m_pc);
    check_nzp(tag, m_nzp);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; thread_en = 1; phase = 3'd6; cur_pc = 8'd77; sel_branch = 1;
    nzp_wr_en = 1; cond_mask = 3'b111; target = 8'd200; cmp_code = 3'b100;
    m_pc = 0; m_nzp = 0;
    @(negedge clk); @(posedge clk); @(negedge clk);
    // R1: reset clears both outputs even with update controls active
    check_pc("R1", 8'd0);
    check_nzp("R1", 3'b000);
    rst = 0;

    // R2 R3: sweep every current PC through the increment path
    for (int p = 0; p < 256; p++)
      step(1, 3'd6, 8'(p), 0, 0, 3'b111, 8'd9, 3'b001, (p == 255) ? "R3" : "R2");
    step(1, 3'd6, 8'd255, 0, 0, 3'b000, 8'd0, 3'b000, "R3");
    check_pc("R3", 8'd0);

    // R4 R6 R7: each single flag against every mask, branch on and off
    for (int f = 0; f < 3; f++) begin
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 2; s++) begin
          step(1, 3'd6, 8'd10, 0, 1, 3'b000, 8'd0, 3'(1 << f), "R4");
          step(1, 3'd6, 8'(40 + m), 1'(s), 0, 3'(m), 8'(128 + 8 * f + m), 3'b000,
               (s == 1 && ((m >> f) & 1) == 1) ? "R6" : "R7");
        end
      end
    end

    // R4 directed: zero flag then negative flag
    step(1, 3'd6, 8'd1, 0, 1, 3'b000, 8'd0, 3'b010, "R4");
    check_nzp("R4", 3'b010);
    // R5: write enable low keeps flags
    step(1, 3'd6, 8'd2, 0, 0, 3'b000, 8'd0, 3'b100, "R5");
    check_nzp("R5", 3'b010);
    // R7: mask 000 never taken
    step(1, 3'd6, 8'd50, 1, 0, 3'b000, 8'd250, 3'b000, "R7");
    check_pc("R7", 8'd51);

    // R8 R9: every non-update phase, and every phase with the thread disabled
    for (int ph = 0; ph < 8; ph++) begin
      if (ph != 6) step(1, 3'(ph), 8'd90, 1, 1, 3'b111, 8'd33, 3'b001, "R8");
      step(0, 3'(ph), 8'd91, 1, 1, 3'b111, 8'd34, 3'b100, "R9");
    end
    check_pc("R8", 8'd51);
    check_nzp("R9", 3'b010);

    // R10: compare write and branch on the same edge use the old flags
    for (int old_f = 0; old_f < 3; old_f++) begin
      for (int new_f = 0; new_f < 3; new_f++) begin
        if (old_f != new_f) begin
          step(1, 3'd6, 8'd5, 0, 1, 3'b000, 8'd0, 3'(1 << old_f), "R10");
          step(1, 3'd6, 8'd60, 1, 1, 3'(1 << old_f), 8'd222, 3'(1 << new_f), "R10");
          check_pc("R10", 8'd222);
          check_nzp("R10", 3'(1 << new_f));
          step(1, 3'd6, 8'd5, 0, 1, 3'b000, 8'd0, 3'(1 << old_f), "R10");
          step(1, 3'd6, 8'd70, 1, 1, 3'(1 << new_f), 8'd223, 3'(1 << new_f), "R10");
          check_pc("R10", 8'd71);
        end
      end
    end

    // R1: reset mid-run clears state again
    rst = 1;
    @(posedge clk); @(negedge clk);
    m_pc = 0; m_nzp = 0;
    check_pc("R1", 8'd0);
    check_nzp("R1", 3'b000);
    rst = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule